// File: doc/BRIEF.md
# Floppy Drive Interrupt Status Tracker

This block holds the head-position and interrupt bookkeeping for a set of floppy drives behind one controller. Each drive has a current track, a ready flag, a pending-interrupt flag and a stored status-0 byte. A command decoder upstream hands the block one decoded command per strobe. The strobe carries an opcode, a drive number, a head number and a target cylinder. The block runs positioning commands (seek to cylinder, recalibrate to track 0) and the two status queries (sense interrupt status, sense drive status). Head movement takes effect at once; step timing and data transfer belong to other blocks.

Every command produces a registered result one clock after its strobe. The result carries a byte count and up to two result bytes. All drives share one interrupt request. A positioning command raises it. The request stays high until sense-interrupt-status commands have cleared the pending flag of every drive. Sense interrupt status reports the lowest-numbered drive that has a pending interrupt. When no drive is pending, it reports again the drive it reported last.

Top module: `fdc_drive_tracker`

## Requirements
- R1: A seek (opcode 0) sets the addressed drive's track to the cylinder given with the command.
- R2: A recalibrate (opcode 1) sets the addressed drive's track to 0.
- R3: After a seek or recalibrate, the drive's status-0 byte is its drive number OR 0x20, its pending flag is set and irq is high on the next cycle.
- R4: A seek or recalibrate copies the drive's disk_present bit into its ready flag.
- R5: Sense interrupt status (opcode 2) reports the lowest-numbered drive whose pending flag is set.
- R6: When no pending flag is set, sense interrupt status reports the drive it reported last; after reset this is drive 0.
- R7: Sense interrupt status returns 2 bytes: byte 0 is the chosen drive's status-0 byte and byte 1 is its track. It then clears that drive's pending flag and bits 7:6 of its status byte.
- R8: irq goes low only on the cycle after a sense interrupt status that leaves no drive pending. While any drive is pending, irq stays high.
- R9: Sense drive status (opcode 3) returns 1 byte. Bits 1:0 hold the drive number and bit 2 holds the head. Bit 4 (0x10) is set when the track is 0 and bit 5 (0x20) when the drive is ready. Bits 7:6 (write protect included) are 0.
- R10: A pulse on disk_insert for a drive clears its ready flag until that drive's next seek or recalibrate.
- R11: Reset clears every track, ready flag, pending flag and status byte, drops irq and res_valid, and sets the last-reported drive to 0.
- R12: res_valid pulses for exactly the cycle after each cmd_valid. res_count is 0 for seek and recalibrate, 2 for sense interrupt status and 1 for sense drive status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 2 | Opcode: 0 seek, 1 recalibrate, 2 sense interrupt status, 3 sense drive status |
| cmd_drive | input | DRV_W (2) | Addressed drive |
| cmd_head | input | 1 | Head select |
| cmd_cyl | input | TRACK_W (8) | Seek target cylinder |
| disk_present | input | NUM_DRIVES (4) | Disk-in-drive level, one bit per drive |
| disk_insert | input | NUM_DRIVES (4) | One-cycle pulse when a disk is put in a drive |
| res_valid | output | 1 | Result for the previous command is valid |
| res_count | output | 2 | Number of valid result bytes |
| res_byte0 | output | 8 | First result byte |
| res_byte1 | output | 8 | Second result byte |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench raises interrupts on two drives at once and checks that sense interrupt status drains them lowest first. A design with a reversed priority would report drive 1 before drive 0. A design that cleared irq after the first drive was served would drop the request while another drive is still pending. It also issues sense interrupt status with nothing pending, both after reset and after several reports, to catch a design that forgets the last reported drive or does not reset it to 0. Sense drive status is read before and after a disk insertion and a recalibrate, which exposes a ready flag that ignores the insert pulse or is never refreshed from disk_present.

// File: rtl/fdc_trk_pkg.sv
package fdc_trk_pkg;

  typedef enum logic [1:0] {
    OP_SEEK      = 2'd0,
    OP_RECAL     = 2'd1,
    OP_SENSE_INT = 2'd2,
    OP_SENSE_DRV = 2'd3
  } trk_op_e;

  localparam logic [7:0] ST0_SEEK_END = 8'h20;
  localparam logic [7:0] ST3_TRACK0   = 8'h10;
  localparam logic [7:0] ST3_READY    = 8'h20;

endpackage

// File: rtl/fdc_trk_drive.sv
module fdc_trk_drive #(
  parameter int TRACK_W = 8,
  parameter int DRV_IDX = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               move_en,
  input  logic [TRACK_W-1:0] move_cyl,
  input  logic               disk_present,
  input  logic               disk_insert,
  input  logic               ack,
  output logic [TRACK_W-1:0] track,
  output logic               ready,
  output logic               pending,
  output logic [7:0]         st0
);
  import fdc_trk_pkg::*;

  localparam logic [7:0] ST0_DONE = 8'(DRV_IDX) | ST0_SEEK_END;

  always_ff @(posedge clk) begin
    if (rst) begin
      track   <= '0;
      ready   <= 1'b0;
      pending <= 1'b0;
      st0     <= '0;
    end else if (move_en) begin
      track   <= move_cyl;
      ready   <= disk_present;
      pending <= 1'b1;
      st0     <= ST0_DONE;
    end else begin
      if (disk_insert) ready <= 1'b0;
      if (ack) begin
        pending  <= 1'b0;
        st0[7:6] <= 2'b00;
      end
    end
  end

endmodule

// File: rtl/fdc_trk_pick.sv
module fdc_trk_pick #(
  parameter int NUM_DRIVES = 4,
  parameter int DRV_W      = 2
) (
  input  logic [NUM_DRIVES-1:0] pending,
  input  logic [DRV_W-1:0]      last_idx,
  output logic [DRV_W-1:0]      sel_idx,
  output logic [NUM_DRIVES-1:0] grant
);
  always_comb begin
    sel_idx = last_idx;
    grant   = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        sel_idx = DRV_W'(i);
        grant   = NUM_DRIVES'(1) << i;
      end
    end
  end

endmodule

// File: rtl/fdc_drive_tracker.sv
module fdc_drive_tracker #(
  parameter int NUM_DRIVES = 4,
  parameter int TRACK_W    = 8,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [DRV_W-1:0]      cmd_drive,
  input  logic                  cmd_head,
  input  logic [TRACK_W-1:0]    cmd_cyl,
  input  logic [NUM_DRIVES-1:0] disk_present,
  input  logic [NUM_DRIVES-1:0] disk_insert,
  output logic                  res_valid,
  output logic [1:0]            res_count,
  output logic [7:0]            res_byte0,
  output logic [7:0]            res_byte1,
  output logic                  irq
);
  import fdc_trk_pkg::*;

  logic [TRACK_W-1:0]    trk   [NUM_DRIVES];
  logic [7:0]            st0   [NUM_DRIVES];
  logic [NUM_DRIVES-1:0] rdy_vec;
  logic [NUM_DRIVES-1:0] pend_vec;
  logic [NUM_DRIVES-1:0] move_vec;
  logic [NUM_DRIVES-1:0] ack_vec;
  logic [NUM_DRIVES-1:0] grant;
  logic [DRV_W-1:0]      last_idx;
  logic [DRV_W-1:0]      sel_idx;
  logic                  is_move;
  logic                  is_sint;
  logic                  is_sdrv;
  logic [TRACK_W-1:0]    move_cyl;
  logic                  irq_d;

  trk_op_e op;
  assign op       = trk_op_e'(cmd_op);
  assign is_move  = cmd_valid && (op == OP_SEEK || op == OP_RECAL);
  assign is_sint  = cmd_valid && (op == OP_SENSE_INT);
  assign is_sdrv  = cmd_valid && (op == OP_SENSE_DRV);
  assign move_cyl = (op == OP_SEEK) ? cmd_cyl : '0;

  fdc_trk_pick #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_pick (
    .pending  (pend_vec),
    .last_idx (last_idx),
    .sel_idx  (sel_idx),
    .grant    (grant)
  );

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign move_vec[g] = is_move && (cmd_drive == DRV_W'(g));
    assign ack_vec[g]  = is_sint && (sel_idx == DRV_W'(g));

    fdc_trk_drive #(.TRACK_W(TRACK_W), .DRV_IDX(g)) u_drv (
      .clk          (clk),
      .rst          (rst),
      .move_en      (move_vec[g]),
      .move_cyl     (move_cyl),
      .disk_present (disk_present[g]),
      .disk_insert  (disk_insert[g]),
      .ack          (ack_vec[g]),
      .track        (trk[g]),
      .ready        (rdy_vec[g]),
      .pending      (pend_vec[g]),
      .st0          (st0[g])
    );
  end

  assign irq_d = (|(pend_vec & ~ack_vec)) | is_move;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_count <= 2'd0;
      res_byte0 <= '0;
      res_byte1 <= '0;
      last_idx  <= '0;
      irq       <= 1'b0;
    end else begin
      res_valid <= cmd_valid;
      irq       <= irq_d;
      if (is_move) begin
        res_count <= 2'd0;
      end else if (is_sint) begin
        res_count <= 2'd2;
        res_byte0 <= st0[sel_idx];
        res_byte1 <= 8'(trk[sel_idx]);
        last_idx  <= sel_idx;
      end else if (is_sdrv) begin
        res_count <= 2'd1;
        res_byte0 <= 8'({cmd_head, cmd_drive})
                   | ((trk[cmd_drive] == '0) ? ST3_TRACK0 : 8'h00)
                   | (rdy_vec[cmd_drive] ? ST3_READY : 8'h00);
        res_byte1 <= '0;
      end
    end
  end

endmodule

// File: rtl/fdc_drive_tracker_chk.sv
module fdc_drive_tracker_chk #(
  parameter int NUM_DRIVES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_op,
  input logic                  res_valid,
  input logic [1:0]            res_count,
  input logic [7:0]            res_byte0,
  input logic                  irq,
  input logic [NUM_DRIVES-1:0] pend_vec,
  input logic [NUM_DRIVES-1:0] grant
);
  // R3
  move_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op[1] == 1'b0) |=> (irq && pend_vec != '0));

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(cmd_valid && cmd_op == 2'd2));

  // R8
  irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (pend_vec != '0));

  // R12
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> res_valid);

  // R12
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !res_valid);

  // R7
  sint_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=> res_count == 2'd2);

  // R9
  sdrv_top_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_count == 2'd1) |-> res_byte0[7:6] == 2'b00);

  // R5
  grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

endmodule

bind fdc_drive_tracker fdc_drive_tracker_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .res_valid (res_valid),
  .res_count (res_count),
  .res_byte0 (res_byte0),
  .irq       (irq),
  .pend_vec  (pend_vec),
  .grant     (grant)
);

// File: tb/sim_fdc_drive_tracker.sv
`timescale 1ns/1ps
module sim_fdc_drive_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [1:0] cmd_drive = '0;
  logic       cmd_head = 1'b0;
  logic [7:0] cmd_cyl = '0;
  logic [3:0] disk_present = 4'b0101;
  logic [3:0] disk_insert = '0;
  logic       res_valid;
  logic [1:0] res_count;
  logic [7:0] res_byte0, res_byte1;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fdc_drive_tracker u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_drive(cmd_drive), .cmd_head(cmd_head), .cmd_cyl(cmd_cyl),
    .disk_present(disk_present), .disk_insert(disk_insert),
    .res_valid(res_valid), .res_count(res_count),
    .res_byte0(res_byte0), .res_byte1(res_byte1), .irq(irq)
  );

  // fields: op[35:34] drv[33:32] head[31] cyl[30:23] cnt[22:21] b0[20:13] b1[12:5] irq[4] pad[3:0]
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {2'd3, 2'd1, 1'b0, 8'd0,  2'd1, 8'h11, 8'h00, 1'b0, 4'h0}, // R9 track0, not ready
    {2'd0, 2'd1, 1'b0, 8'd40, 2'd0, 8'h00, 8'h00, 1'b1, 4'h0}, // R1 R3
    {2'd0, 2'd2, 1'b0, 8'd7,  2'd0, 8'h00, 8'h00, 1'b1, 4'h0}, // R1 R3
    {2'd2, 2'd0, 1'b0, 8'd0,  2'd2, 8'h21, 8'd40, 1'b1, 4'h0}, // R5 R7 R8
    {2'd2, 2'd0, 1'b0, 8'd0,  2'd2, 8'h22, 8'd7,  1'b0, 4'h0}, // R7 R8
    {2'd2, 2'd0, 1'b0, 8'd0,  2'd2, 8'h22, 8'd7,  1'b0, 4'h0}, // R6
    {2'd3, 2'd2, 1'b1, 8'd0,  2'd1, 8'h26, 8'h00, 1'b0, 4'h0}, // R4 R9
    {2'd3, 2'd1, 1'b0, 8'd0,  2'd1, 8'h01, 8'h00, 1'b0, 4'h0}, // R4 R9
    {2'd1, 2'd1, 1'b0, 8'd99, 2'd0, 8'h00, 8'h00, 1'b1, 4'h0}, // R2
    {2'd3, 2'd1, 1'b1, 8'd0,  2'd1, 8'h15, 8'h00, 1'b1, 4'h0}, // R2 R9
    {2'd0, 2'd0, 1'b0, 8'd3,  2'd0, 8'h00, 8'h00, 1'b1, 4'h0}, // R3
    {2'd2, 2'd0, 1'b0, 8'd0,  2'd2, 8'h20, 8'd3,  1'b1, 4'h0}, // R5 R8
    {2'd2, 2'd0, 1'b0, 8'd0,  2'd2, 8'h21, 8'd0,  1'b0, 4'h0}, // R5 R8
    {2'd3, 2'd0, 1'b0, 8'd0,  2'd1, 8'h20, 8'h00, 1'b0, 4'h0}  // R4 R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] drv, input logic hd, input logic [7:0] cyl);
    @(negedge clk);
    cmd_op = op; cmd_drive = drv; cmd_head = hd; cmd_cyl = cyl; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 irq", irq, 0);
    check("R11 res_valid", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][35:34], VEC[i][33:32], VEC[i][31], VEC[i][30:23]);
      check($sformatf("R12 res_valid v%0d", i), res_valid, 1);
      check($sformatf("R12 res_count v%0d", i), res_count, VEC[i][22:21]);
      check($sformatf("R8 irq v%0d", i), irq, VEC[i][4]);
      if (VEC[i][22:21] != 2'd0)
        check($sformatf("R7 R9 byte0 v%0d", i), res_byte0, VEC[i][20:13]);
      if (VEC[i][22:21] == 2'd2)
        check($sformatf("R7 byte1 v%0d", i), res_byte1, VEC[i][12:5]);
      @(negedge clk);
      check($sformatf("R12 pulse end v%0d", i), res_valid, 0);
    end

    // R10: insertion clears ready until the next recalibrate
    @(negedge clk); disk_insert = 4'b0001;
    @(negedge clk); disk_insert = 4'b0000;
    send(2'd3, 2'd0, 1'b0, 8'd0);
    check("R10 ready cleared", res_byte0, 8'h00);
    send(2'd1, 2'd0, 1'b0, 8'd0);
    send(2'd3, 2'd0, 1'b0, 8'd0);
    check("R10 R4 ready restored", res_byte0, 8'h30);
    send(2'd2, 2'd0, 1'b0, 8'd0);
    check("R7 st0 d0", res_byte0, 8'h20);
    check("R8 irq low", irq, 0);

    // R8: two seeks on one drive need one sense only
    send(2'd0, 2'd3, 1'b0, 8'd12);
    send(2'd0, 2'd3, 1'b0, 8'd15);
    check("R3 irq high", irq, 1);
    send(2'd2, 2'd0, 1'b0, 8'd0);
    check("R1 track d3", res_byte1, 8'd15);
    check("R3 st0 d3", res_byte0, 8'h23);
    check("R8 irq cleared", irq, 0);

    // R6 R11: last reported drive returns to 0 after reset
    send(2'd0, 2'd2, 1'b0, 8'd9);
    do_reset();
    check("R11 irq after reset", irq, 0);
    send(2'd2, 2'd0, 1'b0, 8'd0);
    check("R6 R11 st0 drive0", res_byte0, 8'h00);
    check("R6 R11 track drive0", res_byte1, 8'h00);
    send(2'd3, 2'd2, 1'b0, 8'd0);
    check("R11 track cleared d2", res_byte0, 8'h12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule